// File: doc/BRIEF.md
# Vectored Level-Sensitive Interrupt Controller

This block gathers 96 level-sensitive interrupt sources, organised as three banks of 32, and reduces them to two processor-facing lines: a normal interrupt request and a fast interrupt request. Each source can be suppressed with a mask bit. Each source can also be steered onto the fast line with a select bit. A read-only vector register gives software the position of the most urgent active source, so a handler can dispatch without scanning the pending bits. The lowest global index is the most urgent.

Software reaches the block through a plain 32-bit register port that decodes a 1 KiB window. Writes take effect on the clock edge where the write strobe is sampled high. Read data is combinational on the address. Every source line is sampled into its pending bit on each clock edge. The two request outputs and the vector are registered from the pending, mask and select state. They therefore reflect a change to that state one edge after it is captured.

Top module: `vic_core`

## Requirements
- R1: Register map, with byte offsets and word-aligned accesses only: 0x00 vector, 0x04 base address, 0x08 protect, 0x0C NMI control. Five banked groups start at 0x10 (pending), 0x20 (fast pending), 0x30 (select), 0x40 (enable) and 0x50 (mask). Within a group, bank b (0..2) sits at group start + 4*b, and source index = 32*b + bit position.
- R2: On every clock edge each pending bit takes the level of its source input, and the pending registers read back that captured level.
- R3: The interrupt request output goes high one edge after any pending bit with a clear mask bit exists, and low one edge after none does.
- R4: The fast interrupt request output goes high one edge after a pending, unmasked source with its select bit set exists, and low otherwise.
- R5: The vector register reads 4 × the global index of the lowest-numbered pending, unmasked source, updated one edge after the state it encodes. It reads 0 when no such source exists. Writes to it are ignored.
- R6: Writes to the pending registers have no effect.
- R7: Fast pending registers reset to zero. A write clears each bit written as 1 and keeps each bit written as 0.
- R8: A write to the base address register stores the value with bits [1:0] forced to zero. The protect and NMI control registers store the written value unchanged.
- R9: Select, enable and mask registers store the written value. The enable register changes neither request output nor the vector.
- R10: A synchronous active-low reset clears every register and both outputs to zero.
- R11: Reads from an unmapped or misaligned offset (such as group start + 0x0C, 0x60 and above, or an address with bits [1:0] nonzero) return zero. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 96 | Level-sensitive interrupt source lines, index = 32*bank + bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 10 | Byte address within the 1 KiB window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions assume the source lines and the register port are sampled only at the rising edge. They also assume the outputs depend only on the state captured at the previous edge, with no combinational path from src_i to irq_o or fiq_o. The bench changes every input half a period away from the rising edge. It holds each write strobe for exactly one cycle. It covers bank-boundary indices (0, 31, 32, 95) and mixed mask/select patterns, including a pseudo-random sweep.

// File: rtl/vic_pkg.sv
// Shared constants for the vectored interrupt controller.
// Assumes byte addressing of 32-bit words and 16-byte group strides.
package vic_pkg;
    // Scalar register word slots inside group 0 (address bits [3:2])
    localparam int unsigned SLOT_VEC  = 0;
    localparam int unsigned SLOT_BASE = 1;
    localparam int unsigned SLOT_PROT = 2;
    localparam int unsigned SLOT_NMI  = 3;

    // Group numbers taken from address bits above bit 3
    typedef enum logic [2:0] {
        GRP_SCALAR = 3'd0,
        GRP_PEND   = 3'd1,
        GRP_FPEND  = 3'd2,
        GRP_SEL    = 3'd3,
        GRP_ENA    = 3'd4,
        GRP_MASK   = 3'd5,
        GRP_NONE   = 3'd7
    } grp_e;
endpackage

// File: rtl/vic_bank.sv
// One bank of per-source state: sampled pending levels, clear-only fast
// pending, select, enable and mask. Assumes the write strobes are decoded
// and one-hot per cycle by the parent.
module vic_bank #(
    parameter int unsigned BANK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] src_lvl,
    input  logic              wr_fpend,
    input  logic              wr_sel,
    input  logic              wr_ena,
    input  logic              wr_mask,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] pend,
    output logic [BANK_W-1:0] fpend,
    output logic [BANK_W-1:0] sel,
    output logic [BANK_W-1:0] ena,
    output logic [BANK_W-1:0] mask,
    output logic [BANK_W-1:0] active,
    output logic [BANK_W-1:0] fast
);
    // Capture source levels and apply software writes to this bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= '0;
            fpend <= '0;
            sel   <= '0;
            ena   <= '0;
            mask  <= '0;
        end else begin
            pend <= src_lvl;
            if (wr_fpend) fpend <= fpend & ~wdata;
            if (wr_sel)   sel   <= wdata;
            if (wr_ena)   ena   <= wdata;
            if (wr_mask)  mask  <= wdata;
        end
    end

    // Unmasked pending sources, and those steered to the fast line
    always_comb begin
        active = pend & ~mask;
        fast   = active & sel;
    end
endmodule

// File: rtl/vic_prio.sv
// Reduces the active source vector to the two request lines and a
// lowest-index vector. Assumes index 0 is the most urgent source.
module vic_prio #(
    parameter int unsigned SRC_N = 96,
    localparam int unsigned IDX_W = $clog2(SRC_N),
    localparam int unsigned VEC_W = IDX_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] active,
    input  logic [SRC_N-1:0] fast,
    output logic             irq_q,
    output logic             fiq_q,
    output logic [VEC_W-1:0] vec_q
);
    logic [IDX_W-1:0] low_idx;

    // Lowest set index: scan downward so the smallest index wins
    always_comb begin
        low_idx = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (active[i]) low_idx = IDX_W'(i);
        end
    end

    // Register the request lines and the byte-scaled vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            fiq_q <= 1'b0;
            vec_q <= '0;
        end else begin
            irq_q <= |active;
            fiq_q <= |fast;
            vec_q <= {low_idx, 2'b00};
        end
    end
endmodule

// File: rtl/vic_core.sv
// Top of the vectored interrupt controller: address decode, scalar
// registers, read multiplexer and per-bank state. Assumes BANKS <= 4 so
// a bank fits in address bits [3:2] of each 16-byte group.
module vic_core #(
    parameter int unsigned BANKS  = 3,
    parameter int unsigned BANK_W = 32,
    parameter int unsigned ADDR_W = 10,
    localparam int unsigned SRC_N = BANKS * BANK_W,
    localparam int unsigned IDX_W = $clog2(SRC_N),
    localparam int unsigned VEC_W = IDX_W + 2,
    localparam int unsigned GF_W  = ADDR_W - 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  src_i,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BANK_W-1:0] reg_wdata,
    output logic [BANK_W-1:0] reg_rdata,
    output logic              irq_o,
    output logic              fiq_o
);
    import vic_pkg::*;

    grp_e              grp;
    logic [1:0]        slot;
    logic              bank_ok;
    logic [BANK_W-1:0] base_q, prot_q, nmi_q;
    logic [VEC_W-1:0]  vec_q;

    logic [BANK_W-1:0] pend_b  [BANKS];
    logic [BANK_W-1:0] fpend_b [BANKS];
    logic [BANK_W-1:0] sel_b   [BANKS];
    logic [BANK_W-1:0] ena_b   [BANKS];
    logic [BANK_W-1:0] mask_b  [BANKS];
    logic [SRC_N-1:0]  pend_all, fpend_all, sel_all, mask_all;
    logic [SRC_N-1:0]  active_all, fast_all;

    // Address decode: group from the upper bits, word slot from [3:2]
    always_comb begin
        slot    = reg_addr[3:2];
        bank_ok = (32'(slot) < BANKS);
        grp     = GRP_NONE;
        if (reg_addr[1:0] == 2'b00) begin
            unique case (reg_addr[ADDR_W-1:4])
                GF_W'(0): grp = GRP_SCALAR;
                GF_W'(1): grp = bank_ok ? GRP_PEND  : GRP_NONE;
                GF_W'(2): grp = bank_ok ? GRP_FPEND : GRP_NONE;
                GF_W'(3): grp = bank_ok ? GRP_SEL   : GRP_NONE;
                GF_W'(4): grp = bank_ok ? GRP_ENA   : GRP_NONE;
                GF_W'(5): grp = bank_ok ? GRP_MASK  : GRP_NONE;
                default:  grp = GRP_NONE;
            endcase
        end
    end

    // Scalar registers: base address (word aligned), protect, NMI control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            prot_q <= '0;
            nmi_q  <= '0;
        end else if (reg_wr && grp == GRP_SCALAR) begin
            case (32'(slot))
                SLOT_BASE: base_q <= {reg_wdata[BANK_W-1:2], 2'b00};
                SLOT_PROT: prot_q <= reg_wdata;
                SLOT_NMI:  nmi_q  <= reg_wdata;
                default:   ;
            endcase
        end
    end

    // One state bank per group of BANK_W sources
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic hit;
        assign hit = reg_wr && (32'(slot) == b);

        vic_bank #(.BANK_W(BANK_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_lvl  (src_i[b*BANK_W +: BANK_W]),
            .wr_fpend (hit && grp == GRP_FPEND),
            .wr_sel   (hit && grp == GRP_SEL),
            .wr_ena   (hit && grp == GRP_ENA),
            .wr_mask  (hit && grp == GRP_MASK),
            .wdata    (reg_wdata),
            .pend     (pend_b[b]),
            .fpend    (fpend_b[b]),
            .sel      (sel_b[b]),
            .ena      (ena_b[b]),
            .mask     (mask_b[b]),
            .active   (active_all[b*BANK_W +: BANK_W]),
            .fast     (fast_all[b*BANK_W +: BANK_W])
        );

        assign pend_all [b*BANK_W +: BANK_W] = pend_b[b];
        assign fpend_all[b*BANK_W +: BANK_W] = fpend_b[b];
        assign sel_all  [b*BANK_W +: BANK_W] = sel_b[b];
        assign mask_all [b*BANK_W +: BANK_W] = mask_b[b];
    end

    vic_prio #(.SRC_N(SRC_N)) u_prio (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active_all),
        .fast   (fast_all),
        .irq_q  (irq_o),
        .fiq_q  (fiq_o),
        .vec_q  (vec_q)
    );

    // Read multiplexer; unmapped or misaligned offsets read zero
    always_comb begin
        reg_rdata = '0;
        if (grp == GRP_SCALAR) begin
            case (32'(slot))
                SLOT_VEC:  reg_rdata = BANK_W'(vec_q);
                SLOT_BASE: reg_rdata = base_q;
                SLOT_PROT: reg_rdata = prot_q;
                default:   reg_rdata = nmi_q;
            endcase
        end else begin
            for (int b = 0; b < BANKS; b++) begin
                if (32'(slot) == b) begin
                    case (grp)
                        GRP_PEND:  reg_rdata = pend_b[b];
                        GRP_FPEND: reg_rdata = fpend_b[b];
                        GRP_SEL:   reg_rdata = sel_b[b];
                        GRP_ENA:   reg_rdata = ena_b[b];
                        GRP_MASK:  reg_rdata = mask_b[b];
                        default:   ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/vic_core_chk.sv
// Temporal checks on the interrupt controller, bound into vic_core.
// Assumes inputs are sampled only at the rising edge.
module vic_core_chk #(
    parameter int unsigned SRC_N  = 96,
    parameter int unsigned VEC_W  = 9,
    parameter int unsigned BANK_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SRC_N-1:0]  src_i,
    input logic [SRC_N-1:0]  pend_all,
    input logic [SRC_N-1:0]  fpend_all,
    input logic [SRC_N-1:0]  sel_all,
    input logic [SRC_N-1:0]  mask_all,
    input logic [BANK_W-1:0] base_q,
    input logic [VEC_W-1:0]  vec_q,
    input logic              irq_o,
    input logic              fiq_o
);
    // Pending capture follows the source lines one edge later, writes or not
    assert_pend_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_all == $past(src_i)));

    // Request line reflects the previous edge's unmasked pending state
    assert_irq_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(pend_all & ~mask_all))));

    // Fast line reflects the previous edge's selected unmasked pending state
    assert_fiq_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fiq_o == $past(|(pend_all & ~mask_all & sel_all))));

    // Fast request never appears without the normal request
    assert_fiq_implies_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> irq_o);

    // Vector is zero when nothing is requesting, and always word aligned
    assert_vec_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (vec_q == '0));
    assert_vec_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_q[1:0] == 2'b00);

    // Fast pending bits can only be cleared, never set
    assert_fpend_clear_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fpend_all & ~$past(fpend_all)) == '0));

    // Base address register keeps its low two bits at zero
    assert_base_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        base_q[1:0] == 2'b00);
endmodule

bind vic_core vic_core_chk #(
    .SRC_N  (SRC_N),
    .VEC_W  (VEC_W),
    .BANK_W (BANK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .pend_all  (pend_all),
    .fpend_all (fpend_all),
    .sel_all   (sel_all),
    .mask_all  (mask_all),
    .base_q    (base_q),
    .vec_q     (vec_q),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o)
);

// File: tb/sim_vic_core.sv
`timescale 1ns/1ps
// Bench for vic_core: a behavioural model updated on every rising edge,
// with outputs compared on every falling edge plus register read checks.
module sim_vic_core;
    localparam int NB = 3;
    localparam int NS = 96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] src_i = '0;
    logic        reg_wr = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o, fiq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Model state
    logic [31:0] m_pend[NB], m_fpend[NB], m_sel[NB], m_ena[NB], m_mask[NB];
    logic [31:0] m_base, m_prot, m_nmi, m_vec;
    logic        m_irq, m_fiq;

    always #4 clk = ~clk;

    vic_core u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    // Model update on each rising edge: outputs from old state, then new state
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) begin
                m_pend[b] = 0; m_fpend[b] = 0; m_sel[b] = 0; m_ena[b] = 0; m_mask[b] = 0;
            end
            m_base = 0; m_prot = 0; m_nmi = 0; m_vec = 0; m_irq = 0; m_fiq = 0;
        end else begin
            int lowest;
            lowest = -1;
            m_irq = 0; m_fiq = 0;
            for (int s = NS - 1; s >= 0; s--) begin
                if (m_pend[s/32][s%32] && !m_mask[s/32][s%32]) begin
                    lowest = s;
                    m_irq = 1;
                    if (m_sel[s/32][s%32]) m_fiq = 1;
                end
            end
            m_vec = (lowest < 0) ? 0 : 32'(lowest * 4);
            for (int b = 0; b < NB; b++) m_pend[b] = src_i[b*32 +: 32];
            if (reg_wr) begin
                int a;
                a = int'(reg_addr);
                if (a == 'h04) m_base = reg_wdata & 32'hFFFF_FFFC;
                else if (a == 'h08) m_prot = reg_wdata;
                else if (a == 'h0C) m_nmi = reg_wdata;
                else for (int b = 0; b < NB; b++) begin
                    if (a == 'h20 + 4*b) m_fpend[b] = m_fpend[b] & ~reg_wdata;
                    if (a == 'h30 + 4*b) m_sel[b] = reg_wdata;
                    if (a == 'h40 + 4*b) m_ena[b] = reg_wdata;
                    if (a == 'h50 + 4*b) m_mask[b] = reg_wdata;
                end
            end
        end
    end

    function automatic logic [31:0] model_read(input int a);
        logic [31:0] r;
        r = 0;
        if (a == 'h00) r = m_vec;
        else if (a == 'h04) r = m_base;
        else if (a == 'h08) r = m_prot;
        else if (a == 'h0C) r = m_nmi;
        else for (int b = 0; b < NB; b++) begin
            if (a == 'h10 + 4*b) r = m_pend[b];
            if (a == 'h20 + 4*b) r = m_fpend[b];
            if (a == 'h30 + 4*b) r = m_sel[b];
            if (a == 'h40 + 4*b) r = m_ena[b];
            if (a == 'h50 + 4*b) r = m_mask[b];
        end
        return r;
    endfunction

    // Per-clock output comparison (R3, R4, R10)
    always @(negedge clk) begin
        if (!done) begin
            n_chk++;
            if (irq_o !== m_irq || fiq_o !== m_fiq) begin
                n_bad++;
                $display("FAIL R3/R4 outputs at %0t: irq=%b fiq=%b expected irq=%b fiq=%b",
                         $time, irq_o, fiq_o, m_irq, m_fiq);
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = 10'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    // Read check against the model, optionally against a fixed expectation
    task automatic rd(input int a, input string tag);
        logic [31:0] exp;
        reg_addr = 10'(a);
        #1;
        exp = model_read(a);
        n_chk++;
        if (reg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s read 0x%03h: got 0x%08h expected 0x%08h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic rd_fix(input int a, input logic [31:0] exp, input string tag);
        reg_addr = 10'(a);
        #1;
        n_chk++;
        if (reg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s read 0x%03h: got 0x%08h expected 0x%08h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic set_src(input logic [95:0] v);
        @(negedge clk);
        src_i = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog
    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10: everything reads zero after reset
        for (int a = 0; a < 'h60; a += 4) rd_fix(a, 32'h0, "R10");

        // R8: base alignment, protect and NMI storage
        wr('h04, 32'hFFFF_FFFF); rd_fix('h04, 32'hFFFF_FFFC, "R8");
        wr('h08, 32'hA5A5_0001); rd_fix('h08, 32'hA5A5_0001, "R8");
        wr('h0C, 32'h1234_5677); rd_fix('h0C, 32'h1234_5677, "R8");

        // R1/R9: distinct per-bank values in select, enable, mask
        for (int b = 0; b < NB; b++) begin
            wr('h30 + 4*b, 32'h1111_0000 * (b + 1));
            wr('h40 + 4*b, 32'h0000_2222 * (b + 1));
            wr('h50 + 4*b, 32'h0303_0000 << b);
        end
        for (int b = 0; b < NB; b++) begin
            rd_fix('h30 + 4*b, 32'h1111_0000 * (b + 1), "R1 select bank");
            rd_fix('h40 + 4*b, 32'h0000_2222 * (b + 1), "R9 enable");
            rd_fix('h50 + 4*b, 32'h0303_0000 << b, "R9 mask");
        end
        for (int b = 0; b < NB; b++) begin
            wr('h30 + 4*b, 0); wr('h50 + 4*b, 0);
        end

        // R2/R3/R5: single source 40 -> vector 160
        set_src(96'h1 << 40);
        rd_fix('h14, 32'h0000_0100, "R2 pending bank1");
        rd_fix('h00, 32'd160, "R5 vector src40");
        // R5: lower sources 5 and 70 added -> vector 20
        set_src((96'h1 << 40) | (96'h1 << 70) | (96'h1 << 5));
        rd_fix('h00, 32'd20, "R5 vector src5");
        // Mask bit 5 -> vector 160
        wr('h50, 32'h20); @(negedge clk);
        rd_fix('h00, 32'd160, "R5 masked src5");
        // R4: select 70 -> fast line
        wr('h38, 32'h40); @(negedge clk);
        n_chk++;
        if (fiq_o !== 1'b1) begin n_bad++; $display("FAIL R4 fiq got %b expected 1", fiq_o); end
        // Mask 40 -> vector 280
        wr('h54, 32'h100); @(negedge clk);
        rd_fix('h00, 32'd280, "R5 vector src70");
        // Mask 70 -> nothing active
        wr('h58, 32'h40); @(negedge clk);
        rd_fix('h00, 32'd0, "R5 vector idle");
        n_chk++;
        if (irq_o !== 1'b0) begin n_bad++; $display("FAIL R3 irq got %b expected 0", irq_o); end
        for (int b = 0; b < NB; b++) wr('h50 + 4*b, 0);

        // R5 corner: source 0 alone gives vector 0 with request high
        set_src(96'h1);
        rd_fix('h00, 32'd0, "R5 vector src0");
        n_chk++;
        if (irq_o !== 1'b1) begin n_bad++; $display("FAIL R5 irq got %b expected 1", irq_o); end
        // R5 corner: top source 95 -> vector 380; 31 and 32 boundaries
        set_src(96'h1 << 95); rd_fix('h00, 32'd380, "R5 vector src95");
        set_src((96'h1 << 95) | (96'h1 << 32)); rd_fix('h00, 32'd128, "R5 vector src32");
        set_src((96'h1 << 32) | (96'h1 << 31)); rd_fix('h00, 32'd124, "R5 vector src31");

        // R6: writes to pending are ignored
        wr('h10, 32'h0); wr('h14, 32'hFFFF_FFFF);
        rd_fix('h10, 32'h8000_0000, "R6 pending bank0");
        rd_fix('h14, 32'h0000_0001, "R6 pending bank1");
        // R5: writes to the vector register are ignored
        wr('h00, 32'hFFFF_FFFF); rd_fix('h00, 32'd124, "R5 vector write");

        // R7: fast pending clear-only, reads zero
        wr('h20, 32'hFFFF_FFFF); wr('h24, 32'h0);
        rd_fix('h20, 32'h0, "R7 fast pending"); rd_fix('h24, 32'h0, "R7 fast pending");

        // R11: unmapped and misaligned offsets
        wr('h30, 32'hCAFE_0000);
        wr('h3C, 32'h1); wr('h5C, 32'hFFFF_FFFF); wr('h60, 32'hFFFF_FFFF);
        wr('h31, 32'hFFFF_FFFF); wr('h3FC, 32'hFFFF_FFFF); wr('h05, 32'h0);
        rd_fix('h30, 32'hCAFE_0000, "R11 select after stray writes");
        rd_fix('h04, 32'hFFFF_FFFC, "R11 base after stray write");
        rd_fix('h3C, 32'h0, "R11 unmapped read");
        rd_fix('h60, 32'h0, "R11 unmapped read");
        rd_fix('h31, 32'h0, "R11 misaligned read");
        rd_fix('h1C, 32'h0, "R11 unmapped read");
        wr('h30, 0);

        // R9: enable has no effect on the outputs (per-clock compare covers it)
        set_src(96'h1 << 50);
        wr('h44, 32'h0); wr('h44, 32'hFFFF_FFFF); wr('h44, 32'h0);
        rd_fix('h00, 32'd200, "R9 vector with enable toggled");

        // Pseudo-random sweep with per-clock compare and vector reads (R2-R5)
        lfsr = 32'hACE1_1357;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            src_i = {lfsr, ~lfsr, lfsr ^ 32'h5A5A_5A5A} & {3{lfsr[7] ? 32'h0000_0F00 : 32'hFFFF_FFFF}};
            if (k % 7 == 0) wr('h50 + 4*(k % 3), lfsr ^ 32'h0F0F_F0F0);
            if (k % 11 == 0) wr('h30 + 4*(k % 3), ~lfsr);
            rd('h00, "R5 sweep vector");
            rd('h10 + 4*(k % 3), "R2 sweep pending");
        end

        // R10: reset mid-run clears all state
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        for (int a = 0; a < 'h60; a += 4) begin
            if (a < 'h10 || a >= 'h20) rd_fix(a, 32'h0, "R10 after reset");
        end
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule